// File: doc/BRIEF.md
# TDM Time Slot Assigner

This block is the slot engine for one channel of a serial time-division backplane. The backplane has a bit clock and an 8 kHz frame strobe. From the frame strobe the block counts bit positions. Two six-bit slot numbers pick which window of the incoming serial stream is gathered into a parallel word, and which window of the outgoing stream is driven from a parallel word. Outside its own window the output is released (output enable low).

Slot size follows the channel's coding direction. When compressing, the input window is a full 8-bit sample and the output window is a 4-bit code. When expanding, the two sizes swap. The companding law picks a frame organisation, and both laws give the same number of slots by default. A strobe lasting two bit clocks marks a signaling frame, and the block flags it. The codec arithmetic lives elsewhere.

The bit clock and the frame strobe are oversampled by the system clock `clk`. The block finds their edges on that clock, so the whole block runs in one clock domain.

Top module: `tdm_slot_assigner`

## Requirements
- R1: After reset, serOutOe, rxValid, txLoad and sigFrame are 0. No slot is active until the first frame strobe is seen, so serOutOe stays 0 and rxValid does not pulse.
- R2: Bit 0 of a frame is the first tdmClk rising edge at which frameSync is high and was low at the previous rising edge. Each later rising edge advances the bit position by one, also while a wide strobe is still high.
- R3: In compress mode (compress=1) the input slot is 8 bits wide. serIn is sampled on tdmClk falling edges, MSB first. The word appears on rxWord with rxValid high for exactly one clk cycle, one clk after the falling edge of its last bit.
- R4: In expand mode (compress=0) the input slot is 4 bits wide. The code appears MSB first in rxWord[3:0], and rxWord[7:4] reads 0.
- R5: serOut and serOutOe change only on tdmClk rising edges. serOutOe is 1 exactly during the bits of the assigned output slot. In compress mode the slot is 4 bits and sends txWord[3:0] MSB first. In expand mode it is 8 bits and sends txWord[7:0] MSB first.
- R6: txLoad pulses once per frame for one clk, at the rising edge that starts the output slot. That is the edge at which txWord is taken and its first bit is driven.
- R7: The slot index is the bit position divided by the slot width. A frame holds 32 byte slots or 64 nibble slots. A slot number at or beyond that count never matches.
- R8: With hwMode=1 the inSlot and outSlot inputs are ignored, and both slots are slot 0.
- R9: sigFrame goes to 1 after a frame strobe two bit clocks wide. It returns to 0 after a strobe one bit clock wide. It changes only at the rising edge where the strobe is first seen low.
- R10: Both companding laws (muLaw=1 or 0) give the same slot layout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the backplane |
| rstN | input | 1 | Active-low synchronous reset |
| tdmClk | input | 1 | Backplane bit clock |
| frameSync | input | 1 | Frame strobe, high for one or two bit clocks |
| serIn | input | 1 | Serial data in |
| serOut | output | 1 | Serial data out |
| serOutOe | output | 1 | Drive enable for serOut; 0 means released |
| compress | input | 1 | 1 = 8-bit in / 4-bit out, 0 = 4-bit in / 8-bit out |
| muLaw | input | 1 | Companding law select |
| hwMode | input | 1 | 1 forces both slots to 0 |
| inSlot | input | 6 | Input slot number |
| outSlot | input | 6 | Output slot number |
| txWord | input | 8 | Word to send in the output slot |
| txLoad | output | 1 | One-cycle pulse when txWord is taken |
| rxWord | output | 8 | Word gathered from the input slot |
| rxValid | output | 1 | One-cycle pulse marking a new rxWord |
| sigFrame | output | 1 | Current frame is a signaling frame |

## Verification
Output bits and serOutOe settle one clk after the clk edge that sees tdmClk rise. The bench reads them in the middle of the high phase, three clk cycles after the rise. rxValid and rxWord follow the edge that sees the last bit's fall by one clk. A monitor on every clk edge catches them there and counts the pulses, so a missing or repeated word shows up. sigFrame is read once the strobe has dropped and the whole frame has run.

// File: rtl/tsa_pkg.sv
package tsa_pkg;
  // strobes from control to datapath, all valid for one clk
  typedef struct packed {
    logic rise;      // tdmClk rising edge seen this cycle
    logic inHit;     // falling edge inside input slot
    logic inLast;    // falling edge on last bit of input slot
    logic outHit;    // rising edge starts a bit of output slot
    logic outFirst;  // rising edge starts the first bit of output slot
  } tsaStrobe_t;
endpackage

// File: rtl/tsa_ctrl.sv
module tsa_ctrl
  import tsa_pkg::*;
#(
  parameter int BYTE_SLOTS_MU = 32,
  parameter int BYTE_SLOTS_A  = 32,
  parameter int SLOT_W        = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tdmClk,
  input  logic              frameSync,
  input  logic              compress,
  input  logic              muLaw,
  input  logic              hwMode,
  input  logic [SLOT_W-1:0] inSlot,
  input  logic [SLOT_W-1:0] outSlot,
  output tsaStrobe_t        stb,
  output logic              sigFrame
);
  localparam int MAX_BYTES  = (BYTE_SLOTS_MU > BYTE_SLOTS_A) ? BYTE_SLOTS_MU : BYTE_SLOTS_A;
  localparam int FRAME_BITS = 8 * MAX_BYTES;
  localparam int CNT_W      = $clog2(FRAME_BITS) + 1;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic             tdmClkD, fsPrev, frameValid;
  logic [CNT_W-1:0] bitCnt, nextCnt;
  logic [1:0]       fsWidth;
  logic             rise, fall, syncStart;
  logic [CNT_W-1:0] byteSlots, inIdx, outIdx, inLimit, outLimit;
  logic [2:0]       inPos, outPos;
  logic [SLOT_W-1:0] inSel, outSel;
  logic             inMatch, outMatch;

  assign rise      = tdmClk & ~tdmClkD;
  assign fall      = ~tdmClk & tdmClkD;
  assign syncStart = rise & frameSync & ~fsPrev;
  assign nextCnt   = syncStart ? '0 : ((bitCnt == CNT_MAX) ? bitCnt : bitCnt + 1'b1);
  assign byteSlots = muLaw ? CNT_W'(BYTE_SLOTS_MU) : CNT_W'(BYTE_SLOTS_A);
  assign inSel     = hwMode ? '0 : inSlot;
  assign outSel    = hwMode ? '0 : outSlot;

  // input side: nibble slots when expanding, counted on current bit
  always_comb begin
    if (compress) begin
      inIdx   = bitCnt >> 3;
      inPos   = bitCnt[2:0];
      inLimit = byteSlots;
      outIdx  = nextCnt >> 2;
      outPos  = {1'b0, nextCnt[1:0]};
      outLimit = byteSlots << 1;
    end else begin
      inIdx   = bitCnt >> 2;
      inPos   = {1'b0, bitCnt[1:0]};
      inLimit = byteSlots << 1;
      outIdx  = nextCnt >> 3;
      outPos  = nextCnt[2:0];
      outLimit = byteSlots;
    end
  end

  assign inMatch  = frameValid & (inIdx == CNT_W'(inSel)) & (inIdx < inLimit);
  assign outMatch = (frameValid | syncStart) & (outIdx == CNT_W'(outSel)) & (outIdx < outLimit);

  assign stb.rise     = rise;
  assign stb.inHit    = fall & inMatch;
  assign stb.inLast   = fall & inMatch & (inPos == (compress ? 3'd7 : 3'd3));
  assign stb.outHit   = rise & outMatch;
  assign stb.outFirst = rise & outMatch & (outPos == 3'd0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tdmClkD    <= 1'b0;
      fsPrev     <= 1'b0;
      frameValid <= 1'b0;
      bitCnt     <= CNT_MAX;
      fsWidth    <= '0;
      sigFrame   <= 1'b0;
    end else begin
      tdmClkD <= tdmClk;
      if (rise) begin
        fsPrev <= frameSync;
        bitCnt <= nextCnt;
        if (syncStart) begin
          frameValid <= 1'b1;
          fsWidth    <= 2'd1;
        end else if (frameSync && fsPrev && fsWidth != 2'd3) begin
          fsWidth <= fsWidth + 2'd1;
        end
        if (!frameSync && fsPrev) sigFrame <= (fsWidth == 2'd2);
      end
    end
  end

  a_r9_sig_on_rise: assert property (@(posedge clk) disable iff (!rstN)
    !$past(rise) |-> $stable(sigFrame));
  a_r2_sync_restarts: assert property (@(posedge clk) disable iff (!rstN)
    $past(syncStart) |-> (bitCnt == '0));
endmodule

// File: rtl/tsa_datapath.sv
module tsa_datapath
  import tsa_pkg::*;
#(
  parameter int WORD_W = 8,
  parameter int NIB_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  tsaStrobe_t        stb,
  input  logic              compress,
  input  logic              serIn,
  input  logic [WORD_W-1:0] txWord,
  output logic [WORD_W-1:0] rxWord,
  output logic              rxValid,
  output logic              serOut,
  output logic              serOutOe,
  output logic              txLoad
);
  localparam int SH_W = WORD_W - 1;

  logic [SH_W-1:0] inShift, outShift;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      inShift <= '0;
      rxWord  <= '0;
      rxValid <= 1'b0;
    end else begin
      rxValid <= stb.inLast;
      if (stb.inHit) inShift <= {inShift[SH_W-2:0], serIn};
      if (stb.inLast) begin
        if (compress) rxWord <= {inShift, serIn};
        else          rxWord <= {{(WORD_W-NIB_W){1'b0}}, inShift[NIB_W-2:0], serIn};
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outShift <= '0;
      serOut   <= 1'b0;
      serOutOe <= 1'b0;
      txLoad   <= 1'b0;
    end else begin
      txLoad <= stb.outFirst;
      if (stb.rise) begin
        serOutOe <= stb.outHit;
        if (stb.outFirst) begin
          if (compress) begin
            serOut   <= txWord[NIB_W-1];
            outShift <= {txWord[NIB_W-2:0], {(WORD_W-NIB_W){1'b0}}};
          end else begin
            serOut   <= txWord[WORD_W-1];
            outShift <= txWord[SH_W-1:0];
          end
        end else if (stb.outHit) begin
          serOut   <= outShift[SH_W-1];
          outShift <= outShift << 1;
        end else begin
          serOut <= 1'b0;
        end
      end
    end
  end

  a_r3_rx_single: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |=> !rxValid);
  a_r5_out_on_rise: assert property (@(posedge clk) disable iff (!rstN)
    !$past(stb.rise) |-> ($stable(serOutOe) && $stable(serOut)));
  a_r6_load_drives: assert property (@(posedge clk) disable iff (!rstN)
    txLoad |-> serOutOe);
endmodule

// File: rtl/tdm_slot_assigner.sv
module tdm_slot_assigner
  import tsa_pkg::*;
#(
  parameter int BYTE_SLOTS_MU = 32,
  parameter int BYTE_SLOTS_A  = 32,
  parameter int SLOT_W        = 6,
  parameter int WORD_W        = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tdmClk,
  input  logic              frameSync,
  input  logic              serIn,
  output logic              serOut,
  output logic              serOutOe,
  input  logic              compress,
  input  logic              muLaw,
  input  logic              hwMode,
  input  logic [SLOT_W-1:0] inSlot,
  input  logic [SLOT_W-1:0] outSlot,
  input  logic [WORD_W-1:0] txWord,
  output logic              txLoad,
  output logic [WORD_W-1:0] rxWord,
  output logic              rxValid,
  output logic              sigFrame
);
  tsaStrobe_t stb;

  tsa_ctrl #(
    .BYTE_SLOTS_MU(BYTE_SLOTS_MU), .BYTE_SLOTS_A(BYTE_SLOTS_A), .SLOT_W(SLOT_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .tdmClk(tdmClk), .frameSync(frameSync),
    .compress(compress), .muLaw(muLaw), .hwMode(hwMode),
    .inSlot(inSlot), .outSlot(outSlot), .stb(stb), .sigFrame(sigFrame)
  );

  tsa_datapath #(.WORD_W(WORD_W), .NIB_W(WORD_W/2)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .compress(compress), .serIn(serIn),
    .txWord(txWord), .rxWord(rxWord), .rxValid(rxValid),
    .serOut(serOut), .serOutOe(serOutOe), .txLoad(txLoad)
  );
endmodule

// File: tb/tdm_slot_assigner_tb.sv
module tdm_slot_assigner_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tdmClk = 1'b0, frameSync = 1'b0, serIn = 1'b0;
  logic compress = 1'b1, muLaw = 1'b1, hwMode = 1'b0;
  logic [5:0] inSlot = '0, outSlot = '0;
  logic [7:0] txWord = '0;
  logic serOut, serOutOe, txLoad, rxValid, sigFrame;
  logic [7:0] rxWord;

  int checks = 0, errors = 0;
  int rxCount = 0, loadCount = 0;
  logic [7:0] rxLast = '0;
  logic oeLog [256];
  logic outLog [256];
  logic done = 1'b0;

  always #10 clk = ~clk;

  tdm_slot_assigner u_dut (
    .clk(clk), .rstN(rstN), .tdmClk(tdmClk), .frameSync(frameSync), .serIn(serIn),
    .serOut(serOut), .serOutOe(serOutOe), .compress(compress), .muLaw(muLaw),
    .hwMode(hwMode), .inSlot(inSlot), .outSlot(outSlot), .txWord(txWord),
    .txLoad(txLoad), .rxWord(rxWord), .rxValid(rxValid), .sigFrame(sigFrame)
  );

  always @(posedge clk) begin
    if (rxValid) begin rxCount <= rxCount + 1; rxLast <= rxWord; end
    if (txLoad) loadCount <= loadCount + 1;
  end

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic oneBit(logic fs, logic din, int idx);
    @(negedge clk); tdmClk = 1'b1; frameSync = fs; serIn = din;
    repeat (3) @(negedge clk);
    if (idx >= 0) begin oeLog[idx] = serOutOe; outLog[idx] = serOut; end
    @(negedge clk); tdmClk = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic runFrame(int fsW, logic [255:0] din);
    @(negedge clk); rxCount = 0; loadCount = 0;
    for (int b = 0; b < 256; b++) oneBit(b < fsW, din[b], b);
  endtask

  // bits lo..hi must be driven with value pattern; all others released
  task automatic checkOut(string req, int lo, int n, logic [7:0] pat);
    int bad = 0, dbad = 0;
    for (int b = 0; b < 256; b++) begin
      if (oeLog[b] !== ((b >= lo) && (b < lo + n))) bad++;
      if ((b >= lo) && (b < lo + n) && outLog[b] !== pat[n-1-(b-lo)]) dbad++;
    end
    check(req, "oe window mismatches", bad, 0);
    check(req, "out data mismatches", dbad, 0);
  endtask

  function automatic logic [255:0] place(int lo, int n, logic [7:0] w);
    logic [255:0] d = '0;
    for (int i = 0; i < n; i++) d[lo + i] = w[n-1-i];
    return d;
  endfunction

  task automatic testReset();
    check("R1", "serOutOe", serOutOe, 0);
    check("R1", "rxValid", rxValid, 0);
    check("R1", "txLoad", txLoad, 0);
    check("R1", "sigFrame", sigFrame, 0);
    rxCount = 0;
    for (int b = 0; b < 12; b++) begin
      oneBit(1'b0, 1'b1, -1);
      check("R1", "oe before first sync", serOutOe, 0);
    end
    check("R1", "rx before first sync", rxCount, 0);
  endtask

  task automatic testCompress();
    compress = 1; muLaw = 1; hwMode = 0; inSlot = 3; outSlot = 5; txWord = 8'hFC;
    runFrame(1, place(24, 8, 8'hA5));
    check("R3", "rx count", rxCount, 1);
    check("R3", "rx word", rxLast, 8'hA5);
    checkOut("R5", 20, 4, 8'h0C);
    check("R6", "load count", loadCount, 1);
  endtask

  task automatic testExpand();
    compress = 0; muLaw = 0; hwMode = 0; inSlot = 2; outSlot = 1; txWord = 8'h3C;
    runFrame(1, place(8, 4, 8'h09) | place(0, 8, 8'hFF));
    check("R4", "rx count", rxCount, 1);
    check("R4", "rx nibble", rxLast, 8'h09);
    checkOut("R10", 8, 8, 8'h3C);
  endtask

  task automatic testRange();
    compress = 0; muLaw = 1; hwMode = 0; inSlot = 40; outSlot = 40; txWord = 8'hFF;
    runFrame(1, place(160, 4, 8'h06));
    check("R7", "nibble slot 40 rx", rxLast, 8'h06);
    check("R7", "byte slot 40 never drives", loadCount, 0);
    checkOut("R7", 0, 0, 8'h00);
    compress = 1; inSlot = 31; outSlot = 63; txWord = 8'h05;
    runFrame(1, place(248, 8, 8'h81));
    check("R7", "last byte slot rx", rxLast, 8'h81);
    checkOut("R7", 252, 4, 8'h05);
  endtask

  task automatic testHw();
    compress = 1; muLaw = 1; hwMode = 1; inSlot = 7; outSlot = 9; txWord = 8'h0A;
    runFrame(1, place(0, 8, 8'h5E));
    check("R8", "rx from slot 0", rxLast, 8'h5E);
    check("R8", "rx count", rxCount, 1);
    checkOut("R8", 0, 4, 8'h0A);
    hwMode = 0;
  endtask

  task automatic testSig();
    compress = 1; muLaw = 1; hwMode = 0; inSlot = 0; outSlot = 0; txWord = 8'h09;
    runFrame(2, place(0, 8, 8'h3C));
    check("R9", "sigFrame after wide strobe", sigFrame, 1);
    check("R2", "slot 0 rx under wide strobe", rxLast, 8'h3C);
    checkOut("R2", 0, 4, 8'h09);
    runFrame(1, '0);
    check("R9", "sigFrame after normal strobe", sigFrame, 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testCompress();
    testExpand();
    testRange();
    testHw();
    testSig();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule